// File: doc/BRIEF.md
# Dual-Clock Activity Monitor with Automatic Failover

The block watches two oscillator inputs, an internal oscillator and an external crystal oscillator, from a single system clock domain. Each oscillator passes through a synchronizer and a rising-edge detector. Each one is then judged by counting its edges inside a window. The window length is a fixed number of rising edges of the other oscillator. If the oscillator that currently drives the system clock produces too few edges in its window, the block flips the clock-select output to the other source. The other source is known to be running, because its edges closed the window. The block also records the event in a sticky flag.

A separate stall timer runs for each oscillator in the system domain. If both oscillators go quiet, the window can no longer close, and these timers catch that case: the flag is set and the select output is left where it was. A small control register holds the enables, the select bit and the flag. Software can poll the flag or take a level interrupt. Clearing the flag needs a read that saw the flag set, followed later by a write that carries a zero in the flag position. A read-modify-write that puts the flag value back therefore leaves it alone.

Top module: `clkmon_failover`

## Requirements
- R1: After reset, the control register reads 0x00: monitor off, interrupt enable off, internal source selected (select = 0), flag clear. `clk_sel_o` and `irq_o` are 0.
- R2: Control register layout: bit 0 is monitor enable, bit 1 is interrupt enable, bit 2 is source select (0 = internal, 1 = external) and bit 3 is the failure flag. Bits 7:4 always read 0. A write strobe updates bits 0 to 2 at that clock edge. `reg_rdata_o` always shows the current register state, and `clk_sel_o` follows bit 2.
- R3: A write of 1 to bit 3 never sets the flag.
- R4: The monitor is enabled and the selected oscillator shows fewer than `MIN_EDGES` synchronized rising edges within `WIN_LEN` synchronized rising edges of the other oscillator. The block then sets the flag and switches the select bit to the other oscillator.
- R5: Inactivity of the oscillator that is not selected neither sets the flag nor changes the select bit.
- R6: While the monitor enable is 0, no inactivity sets the flag or changes the select bit.
- R7: With the monitor enabled, both oscillators may show no rising edge for `STALL_LIM` system cycles. The flag is then set and the select bit keeps its value.
- R8: `irq_o` is high exactly while the flag and the interrupt enable are both set. It stays high until the flag is cleared.
- R9: A write clears the flag only if bit 3 of the write data is 0 and a read that returned flag = 1 has happened since the previous write. A write without such a read, or a write with bit 3 = 1, leaves the flag set. Any write uses up the armed read.
- R10: Once set, the flag stays set until an R9 clear, including after the failed oscillator starts running again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all state is in this domain |
| rst_n | input | 1 | Asynchronous active-low reset |
| int_osc_i | input | 1 | Internal oscillator, asynchronous to clk |
| ext_osc_i | input | 1 | External crystal oscillator, asynchronous to clk |
| reg_wr_i | input | 1 | Control register write strobe |
| reg_rd_i | input | 1 | Control register read strobe (arms the flag clear) |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Current control register contents |
| clk_sel_o | output | 1 | Selected source: 0 internal, 1 external |
| irq_o | output | 1 | Level interrupt: flag and interrupt enable |

## Verification
Register writes show on `reg_rdata_o`, `clk_sel_o` and `irq_o` from the edge that samples the strobe onward. The bench drives strobes on the falling edge and reads results at the next falling edge. An oscillator change reaches the edge counters three system cycles later. A failover verdict is therefore due at most two windows plus three cycles after an oscillator stops. A dual stall is due `STALL_LIM` plus three cycles after both stop. With a 32-edge window in the bench, both bounds fall well below the 1000-cycle wait that each directed case allows before it samples. Cases that must show no reaction use the same long wait, so a late, wrong reaction would also be seen.

// File: rtl/cmon_pkg.sv
package cmon_pkg;
    localparam int CTL_W    = 8;
    localparam int BIT_MON  = 0;
    localparam int BIT_IEN  = 1;
    localparam int BIT_SEL  = 2;
    localparam int BIT_FLAG = 3;
    localparam int NUM_SRC  = 2;

    typedef enum logic {
        SRC_INTERNAL = 1'b0,
        SRC_EXTERNAL = 1'b1
    } src_e;
endpackage

// File: rtl/cmon_edge_sync.sv
module cmon_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic osc_i,
    output logic rise_o
);
    typedef struct packed {
        logic [STAGES-1:0] chain;
        logic              last;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.chain = {st_q.chain[STAGES-2:0], osc_i};
        st_d.last  = st_q.chain[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rise_o = st_q.chain[STAGES-1] & ~st_q.last;

    // an edge pulse lasts one cycle: the detector compares two chain taps
    assert_rise_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);
endmodule

// File: rtl/cmon_activity.sv
module cmon_activity #(
    parameter int WIN_LEN   = 256,
    parameter int MIN_EDGES = 2,
    parameter int STALL_LIM = 4096
) (
    input  logic clk,
    input  logic rst_n,
    input  logic watch_rise_i,
    input  logic ref_rise_i,
    output logic dead_o,
    output logic stall_o
);
    localparam int WIN_W  = (WIN_LEN > 1) ? $clog2(WIN_LEN) : 1;
    localparam int EDGE_W = $clog2(MIN_EDGES + 1);
    localparam int GAP_W  = $clog2(STALL_LIM + 1);
    localparam logic [WIN_W-1:0]  WIN_LAST = WIN_W'(WIN_LEN - 1);
    localparam logic [EDGE_W-1:0] EDGE_MIN = EDGE_W'(MIN_EDGES);
    localparam logic [GAP_W-1:0]  GAP_MAX  = GAP_W'(STALL_LIM);

    typedef struct packed {
        logic [WIN_W-1:0]  win_cnt;
        logic [EDGE_W-1:0] edge_cnt;
        logic [GAP_W-1:0]  gap_cnt;
        logic              dead;
    } act_t;

    act_t st_d, st_q;
    logic [EDGE_W-1:0] edge_next;

    always_comb begin
        st_d      = st_q;
        st_d.dead = 1'b0;

        // saturating count of watched edges in the open window
        edge_next = st_q.edge_cnt;
        if (watch_rise_i && (st_q.edge_cnt < EDGE_MIN))
            edge_next = st_q.edge_cnt + 1'b1;
        st_d.edge_cnt = edge_next;

        // window advances on reference edges only
        if (ref_rise_i) begin
            if (st_q.win_cnt == WIN_LAST) begin
                st_d.dead     = (edge_next < EDGE_MIN);
                st_d.win_cnt  = '0;
                st_d.edge_cnt = '0;
            end else begin
                st_d.win_cnt = st_q.win_cnt + 1'b1;
            end
        end

        // system-domain gap timer for the all-quiet case
        if (watch_rise_i)
            st_d.gap_cnt = '0;
        else if (st_q.gap_cnt != GAP_MAX)
            st_d.gap_cnt = st_q.gap_cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dead_o  = st_q.dead;
    assign stall_o = (st_q.gap_cnt == GAP_MAX);

    // a verdict is a single-cycle pulse
    assert_verdict_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        dead_o |=> !dead_o);

    // a stall persists until the watched oscillator produces an edge
    assert_stall_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        stall_o && !watch_rise_i |=> stall_o);

    // an edge ends a stall on the next cycle
    assert_stall_ends_R7: assert property (@(posedge clk) disable iff (!rst_n)
        watch_rise_i |=> !stall_o);
endmodule

// File: rtl/cmon_ctrl_regs.sv
module cmon_ctrl_regs
    import cmon_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_i,
    input  logic             rd_i,
    input  logic [CTL_W-1:0] wdata_i,
    input  logic             fail_evt_i,
    input  logic             fail_switch_i,
    output logic [CTL_W-1:0] rdata_o,
    output logic             mon_en_o,
    output src_e             sel_o,
    output logic             irq_o
);
    typedef struct packed {
        logic mon;
        logic ien;
        src_e sel;
        logic flag;
        logic armed;
    } ctl_t;

    ctl_t st_d, st_q;

    always_comb begin
        st_d = st_q;

        // a read that sees the flag arms the clear
        if (rd_i && st_q.flag)
            st_d.armed = 1'b1;

        if (wr_i) begin
            st_d.mon = wdata_i[BIT_MON];
            st_d.ien = wdata_i[BIT_IEN];
            st_d.sel = src_e'(wdata_i[BIT_SEL]);
            if (st_q.armed && !wdata_i[BIT_FLAG])
                st_d.flag = 1'b0;
            st_d.armed = 1'b0;
        end

        // a detected failure overrides a same-cycle write
        if (fail_evt_i) begin
            st_d.flag = 1'b1;
            if (fail_switch_i)
                st_d.sel = (st_q.sel == SRC_INTERNAL) ? SRC_EXTERNAL : SRC_INTERNAL;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rdata_o           = '0;
        rdata_o[BIT_MON]  = st_q.mon;
        rdata_o[BIT_IEN]  = st_q.ien;
        rdata_o[BIT_SEL]  = st_q.sel;
        rdata_o[BIT_FLAG] = st_q.flag;
    end

    assign mon_en_o = st_q.mon;
    assign sel_o    = st_q.sel;
    assign irq_o    = st_q.flag & st_q.ien;

    // the flag is only ever raised by a failure event
    assert_flag_set_by_event_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.flag) |-> $past(fail_evt_i));

    // a clear follows a write that carried a zero in the flag position
    assert_clear_by_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.flag) |-> $past(wr_i) && !$past(wdata_i[BIT_FLAG]));

    // a clear needs an armed read before the write
    assert_clear_needs_arm_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.flag) |-> $past(st_q.armed));
endmodule

// File: rtl/clkmon_failover.sv
module clkmon_failover
    import cmon_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int WIN_LEN     = 256,
    parameter int MIN_EDGES   = 2,
    parameter int STALL_LIM   = 4096
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             int_osc_i,
    input  logic             ext_osc_i,
    input  logic             reg_wr_i,
    input  logic             reg_rd_i,
    input  logic [CTL_W-1:0] reg_wdata_i,
    output logic [CTL_W-1:0] reg_rdata_o,
    output logic             clk_sel_o,
    output logic             irq_o
);
    logic [NUM_SRC-1:0] osc_raw;
    logic [NUM_SRC-1:0] osc_rise;
    logic [NUM_SRC-1:0] src_dead;
    logic [NUM_SRC-1:0] src_stall;

    assign osc_raw = {ext_osc_i, int_osc_i};

    // index 0 is the internal source, index 1 the external; each is timed by the other
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        cmon_edge_sync #(
            .STAGES (SYNC_STAGES)
        ) u_sync (
            .clk    (clk),
            .rst_n  (rst_n),
            .osc_i  (osc_raw[g]),
            .rise_o (osc_rise[g])
        );

        cmon_activity #(
            .WIN_LEN   (WIN_LEN),
            .MIN_EDGES (MIN_EDGES),
            .STALL_LIM (STALL_LIM)
        ) u_act (
            .clk          (clk),
            .rst_n        (rst_n),
            .watch_rise_i (osc_rise[g]),
            .ref_rise_i   (osc_rise[NUM_SRC-1-g]),
            .dead_o       (src_dead[g]),
            .stall_o      (src_stall[g])
        );
    end

    typedef struct packed {
        logic both_stall;
    } top_t;

    top_t st_d, st_q;
    logic mon_en;
    src_e sel;
    logic sel_dead;
    logic other_stall;
    logic both_now;
    logic fail_evt;
    logic fail_switch;

    always_comb begin
        st_d            = st_q;
        both_now        = &src_stall;
        st_d.both_stall = both_now;
        sel_dead        = src_dead[sel];
        other_stall     = src_stall[~sel];
        fail_evt        = mon_en & (sel_dead | (both_now & ~st_q.both_stall));
        // a closed window proves the other source is alive unless it has stalled since
        fail_switch     = mon_en & sel_dead & ~other_stall;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    cmon_ctrl_regs u_regs (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_i          (reg_wr_i),
        .rd_i          (reg_rd_i),
        .wdata_i       (reg_wdata_i),
        .fail_evt_i    (fail_evt),
        .fail_switch_i (fail_switch),
        .rdata_o       (reg_rdata_o),
        .mon_en_o      (mon_en),
        .sel_o         (sel),
        .irq_o         (irq_o)
    );

    assign clk_sel_o = sel;

    // without a write the select bit moves only on an enabled failover
    assert_sel_moves_on_failover_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_sel_o != $past(clk_sel_o)) && !$past(reg_wr_i)
            |-> $past(mon_en) && reg_rdata_o[BIT_FLAG]);

    // a dual stall never flips the select bit
    assert_dual_stall_keeps_sel_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(both_now) && $past(src_stall[0]) && !$past(reg_wr_i)
            && !$past(sel_dead) |-> clk_sel_o == $past(clk_sel_o));

    // the flag is sticky between writes
    assert_flag_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(reg_rdata_o[BIT_FLAG]) && !$past(reg_wr_i) |-> reg_rdata_o[BIT_FLAG]);

    // with the monitor off the flag cannot rise
    assert_disabled_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(mon_en) |-> !$rose(reg_rdata_o[BIT_FLAG]));
endmodule

// File: tb/clkmon_failover_bench.sv
`timescale 1ns/1ps
module clkmon_failover_bench;
    localparam int WIN   = 32;
    localparam int MINE  = 2;
    localparam int STALL = 64;
    localparam int SETTLE = 1000;
    localparam int NVEC  = 6;

    // {write data, expected read data, expected irq}
    localparam logic [16:0] VEC [NVEC] = '{
        {8'h03, 8'h03, 1'b0},  // R2 enables
        {8'h07, 8'h07, 1'b0},  // R2 select external
        {8'h0B, 8'h03, 1'b0},  // R3 flag bit written as 1 stays 0
        {8'hF1, 8'h01, 1'b0},  // R2 upper bits read zero
        {8'h04, 8'h04, 1'b0},  // R2 select only
        {8'h00, 8'h00, 1'b0}   // R2 all clear
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       int_osc = 1'b0;
    logic       ext_osc = 1'b0;
    bit         int_run = 1'b1;
    bit         ext_run = 1'b1;
    logic       reg_wr = 1'b0;
    logic       reg_rd = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       clk_sel;
    logic       irq;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;
    always begin #17; if (int_run) int_osc = ~int_osc; end
    always begin #23; if (ext_run) ext_osc = ~ext_osc; end

    clkmon_failover #(
        .SYNC_STAGES (2),
        .WIN_LEN     (WIN),
        .MIN_EDGES   (MINE),
        .STALL_LIM   (STALL)
    ) u_clkmon_failover (
        .clk         (clk),
        .rst_n       (rst_n),
        .int_osc_i   (int_osc),
        .ext_osc_i   (ext_osc),
        .reg_wr_i    (reg_wr),
        .reg_rd_i    (reg_rd),
        .reg_wdata_i (reg_wdata),
        .reg_rdata_o (reg_rdata),
        .clk_sel_o   (clk_sel),
        .irq_o       (irq)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic check_all(input string req, input logic [7:0] exp_rd, input logic exp_irq);
        check({req, " rdata"}, reg_rdata, exp_rd);
        check({req, " clk_sel"}, {7'b0, clk_sel}, {7'b0, exp_rd[2]});
        check({req, " irq"}, {7'b0, irq}, {7'b0, exp_irq});
    endtask

    task automatic do_write(input logic [7:0] data);
        reg_wdata = data;
        reg_wr    = 1'b1;
        @(negedge clk);
        reg_wr    = 1'b0;
    endtask

    task automatic do_read();
        reg_rd = 1'b1;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic wait_cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL R1 watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        wait_cycles(4);
        check_all("R1 reset", 8'h00, 1'b0);
        rst_n = 1'b1;
        wait_cycles(2);
        check_all("R1 after release", 8'h00, 1'b0);

        // register vectors
        for (int i = 0; i < NVEC; i++) begin
            do_write(VEC[i][16:9]);
            check_all("R2 vector", VEC[i][8:1], VEC[i][0]);
        end

        // R4 failover of the selected internal source, interrupt disabled
        do_write(8'h01);
        wait_cycles(SETTLE);
        check_all("R4 healthy no flag", 8'h01, 1'b0);
        int_run = 1'b0;
        wait_cycles(SETTLE);
        check_all("R4 failover to external", 8'h0D, 1'b0);

        // R10 flag survives recovery of the failed source
        int_run = 1'b1;
        wait_cycles(SETTLE);
        check_all("R10 sticky after recovery", 8'h0D, 1'b0);

        // R9 write without prior read leaves the flag; R8 irq follows enable
        do_write(8'h07);
        check_all("R9 write without read / R8 irq level", 8'h0F, 1'b1);
        wait_cycles(20);
        check_all("R8 irq stays high", 8'h0F, 1'b1);

        // R9 read then write of 1 keeps the flag and uses the arm
        do_read();
        do_write(8'h0F);
        check_all("R9 write one after read", 8'h0F, 1'b1);
        do_write(8'h07);
        check_all("R9 arm consumed", 8'h0F, 1'b1);

        // R9 proper clear sequence, read and write apart by idle cycles
        do_read();
        wait_cycles(3);
        do_write(8'h07);
        check_all("R9 clear", 8'h07, 1'b0);

        // R5 non-selected source fails
        int_run = 1'b0;
        wait_cycles(SETTLE);
        check_all("R5 non-selected ignored", 8'h07, 1'b0);
        int_run = 1'b1;
        wait_cycles(SETTLE);

        // R6 monitor disabled, selected external stops
        do_write(8'h06);
        ext_run = 1'b0;
        wait_cycles(SETTLE);
        check_all("R6 disabled no detection", 8'h06, 1'b0);
        ext_run = 1'b1;
        wait_cycles(SETTLE);

        // R7 both sources stop with internal selected
        do_write(8'h03);
        wait_cycles(SETTLE);
        check_all("R7 armed healthy", 8'h03, 1'b0);
        int_run = 1'b0;
        ext_run = 1'b0;
        wait_cycles(SETTLE);
        check_all("R7 dual stall keeps select", 8'h0B, 1'b1);

        // R1 reset mid-run restores defaults
        rst_n = 1'b0;
        wait_cycles(2);
        check_all("R1 mid-run reset", 8'h00, 1'b0);
        rst_n = 1'b1;
        int_run = 1'b1;
        ext_run = 1'b1;
        wait_cycles(4);
        check_all("R1 after second release", 8'h00, 1'b0);

        finish_run();
    end
endmodule